// File: doc/BRIEF.md
# SIMT Lane Mask Divergence Stack

This block keeps track of which lanes of a wide vector unit may commit results while structured if/else/endif regions run. A live execution mask holds one bit per lane; a lane writes back only when its bit is set. Per-lane compare outcomes arrive on a condition mask that uses the same bit-to-lane mapping. Each open nesting level owns one stack entry. That entry holds the lanes that still have to run the other arm, or, after the else, the lanes that ran the first arm.

The caller issues one command per single-cycle strobe: IF narrows the mask to the lanes whose condition is set and saves the rest. ELSE swaps the live mask with the saved entry. ENDIF merges the saved entry back and closes the level. A skip flag tells the sequencer that the region body can be jumped over because no lane is active. In pixel mode, an ENDIF that closes the outermost region with no live lane left makes the block issue a null-export pulse and then a terminate pulse, after which it stays halted until a new wavefront is launched.

The control is a four-state machine. RUN accepts commands. EXPORT drives the null-export pulse. TERM drives the terminate pulse. HALT ignores commands. The transitions are: RUN to EXPORT on a killing ENDIF, EXPORT to TERM, TERM to HALT, and any state to RUN on launch.

Top module: `simt_mask_stack`

## Requirements
- R1: After reset the execution mask is all ones, the depth is 0, and skip, overflow, underflow, null-export and terminate are all low.
- R2: A command is encoded on `cmd` as 2'b00 idle, 2'b01 IF, 2'b10 ELSE, 2'b11 ENDIF. An accepted IF with depth below DEPTH makes the mask `old & cond`, saves `old & ~cond` on a new entry, and raises the depth by one.
- R3: An accepted ELSE with depth above 0 makes the mask equal to the top entry and replaces the top entry with the previous mask. The depth is unchanged.
- R4: An accepted ENDIF with depth above 0 makes the mask `old | top` and lowers the depth by one.
- R5: The skip output is high after an IF or ELSE whose resulting mask is all zeros. It is low after an IF or ELSE with a non-zero result, after an ENDIF, and after a launch. Otherwise it holds.
- R6: An IF at depth DEPTH produces a one-cycle overflow pulse and leaves the mask, the depth and the stack unchanged.
- R7: An ELSE or ENDIF at depth 0 produces a one-cycle underflow pulse and leaves the mask and the depth unchanged.
- R8: In pixel mode, an ENDIF that brings the depth from 1 to 0 with a resulting all-zero mask makes null-export high in the next cycle and terminate high in the cycle after that. The block then ignores all commands until a launch.
- R9: An ENDIF that reaches depth 0 with a non-zero mask, or any ENDIF outside pixel mode, produces neither null-export nor terminate.
- R10: A launch loads the mask from `launch_mask`, clears the depth and the skip flag, and returns the block to RUN. A launch has priority over a command in the same cycle.
- R11: Every update appears on the cycle after the strobe. Cycles without a strobe, or with an idle command, leave the mask and the depth unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch | input | 1 | Start a new wavefront |
| launch_mask | input | LANES | Initial lane mask loaded on launch |
| cmd_valid | input | 1 | Single-cycle command strobe |
| cmd | input | 2 | Command: 00 idle, 01 IF, 10 ELSE, 11 ENDIF |
| cond | input | LANES | Per-lane condition mask for IF |
| pixel_mode | input | 1 | Enables termination of a fully inactive wavefront |
| exec_mask | output | LANES | Live execution mask |
| depth | output | $clog2(DEPTH+1) | Number of open nesting levels |
| skip | output | 1 | No lane active after the last IF/ELSE |
| overflow | output | 1 | IF issued with a full stack (pulse) |
| underflow | output | 1 | ELSE/ENDIF issued with an empty stack (pulse) |
| null_export | output | 1 | Null export request (pulse) |
| terminate | output | 1 | Terminate wavefront (pulse) |

## Verification
The bench fills the stack to exactly DEPTH and then issues one more IF. A design with an off-by-one full test would either corrupt a neighbouring entry or refuse a legal level. It issues ELSE and ENDIF on an empty stack, where a design without a guard would read a garbage entry into the mask. It closes the outermost region with a zero mask both in pixel mode and outside it, and also with a non-zero mask. A wrong kill test would either terminate live wavefronts or leave dead ones running. It also sends commands while the block is halted and during the export pulse, and issues a launch in the same cycle as a command, to show that stale commands are dropped and that launch wins.

// File: rtl/simt_mask_pkg.sv
package simt_mask_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'b00,
        CMD_IF    = 2'b01,
        CMD_ELSE  = 2'b10,
        CMD_ENDIF = 2'b11
    } mask_cmd_e;

    typedef enum logic [1:0] {
        WS_RUN    = 2'b00,
        WS_EXPORT = 2'b01,
        WS_TERM   = 2'b10,
        WS_HALT   = 2'b11
    } wave_state_e;

endpackage

// File: rtl/simt_mask_alu.sv
module simt_mask_alu
    import simt_mask_pkg::*;
#(
    parameter int LANES = 64
) (
    input  mask_cmd_e          op,
    input  logic [LANES-1:0]   live,
    input  logic [LANES-1:0]   cond,
    input  logic [LANES-1:0]   top,
    output logic [LANES-1:0]   nxt_live,
    output logic [LANES-1:0]   nxt_entry
);

    logic [LANES-1:0] taken;
    logic [LANES-1:0] merged;

    assign taken  = live & cond;
    assign merged = live | top;

    always_comb begin
        nxt_live  = live;
        nxt_entry = top;
        unique case (op)
            CMD_IF: begin
                nxt_live  = taken;
                nxt_entry = live ^ taken;
            end
            CMD_ELSE: begin
                nxt_live  = merged ^ live;
                nxt_entry = live;
            end
            CMD_ENDIF: begin
                nxt_live  = merged;
                nxt_entry = top;
            end
            default: begin
                nxt_live  = live;
                nxt_entry = top;
            end
        endcase
    end

endmodule

// File: rtl/simt_lane_stack.sv
module simt_lane_stack #(
    parameter int LANES = 64,
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               push,
    input  logic               pop,
    input  logic               repl,
    input  logic [LANES-1:0]   wdata,
    output logic [LANES-1:0]   top,
    output logic [PW-1:0]      level,
    output logic               full,
    output logic               empty
);

    logic [LANES-1:0] mem [DEPTH];

    assign full  = (level == PW'(DEPTH));
    assign empty = (level == '0);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            level <= '0;
        end else if (push && !full) begin
            level <= level + PW'(1);
        end else if (pop && !empty) begin
            level <= level - PW'(1);
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[i] <= '0;
            end else if (push && !full && level == PW'(i)) begin
                mem[i] <= wdata;
            end else if (repl && level == PW'(i + 1)) begin
                mem[i] <= wdata;
            end
        end
    end

    always_comb begin
        top = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (level == PW'(i + 1)) top = mem[i];
        end
    end

endmodule

// File: rtl/simt_wave_ctrl.sv
module simt_wave_ctrl
    import simt_mask_pkg::*;
#(
    parameter int LANES = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch,
    input  logic [LANES-1:0]   launch_mask,
    input  logic               cmd_valid,
    input  mask_cmd_e          op,
    input  logic               pixel_mode,
    input  logic [LANES-1:0]   nxt_live,
    input  logic               full,
    input  logic               empty,
    input  logic               last_level,
    output logic [LANES-1:0]   live,
    output logic               push,
    output logic               pop,
    output logic               repl,
    output logic               clear,
    output logic               running,
    output logic               skip,
    output logic               overflow,
    output logic               underflow,
    output logic               null_export,
    output logic               terminate
);

    wave_state_e state, state_nxt;

    logic accept;
    logic do_if, do_else, do_endif;
    logic ovf_now, unf_now;
    logic kill;

    assign accept   = (state == WS_RUN) && !launch && cmd_valid;
    assign do_if    = accept && (op == CMD_IF) && !full;
    assign do_else  = accept && (op == CMD_ELSE) && !empty;
    assign do_endif = accept && (op == CMD_ENDIF) && !empty;
    assign ovf_now  = accept && (op == CMD_IF) && full;
    assign unf_now  = accept && ((op == CMD_ELSE) || (op == CMD_ENDIF)) && empty;
    assign kill     = do_endif && pixel_mode && last_level && (nxt_live == '0);

    assign push  = do_if;
    assign pop   = do_endif;
    assign repl  = do_else;
    assign clear = launch;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= WS_RUN;
        else        state <= state_nxt;
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        if (launch) begin
            state_nxt = WS_RUN;
        end else begin
            unique case (state)
                WS_RUN:    if (kill) state_nxt = WS_EXPORT;
                WS_EXPORT: state_nxt = WS_TERM;
                WS_TERM:   state_nxt = WS_HALT;
                WS_HALT:   state_nxt = WS_HALT;
                default:   state_nxt = WS_RUN;
            endcase
        end
    end

    // Outputs decoded from state
    always_comb begin
        running     = 1'b0;
        null_export = 1'b0;
        terminate   = 1'b0;
        unique case (state)
            WS_RUN:    running     = 1'b1;
            WS_EXPORT: null_export = 1'b1;
            WS_TERM:   terminate   = 1'b1;
            WS_HALT:   ;
            default:   ;
        endcase
    end

    // Live mask, skip flag and error pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live      <= '1;
            skip      <= 1'b0;
            overflow  <= 1'b0;
            underflow <= 1'b0;
        end else begin
            overflow  <= ovf_now;
            underflow <= unf_now;
            if (launch) begin
                live <= launch_mask;
                skip <= 1'b0;
            end else if (do_if || do_else) begin
                live <= nxt_live;
                skip <= (nxt_live == '0);
            end else if (do_endif) begin
                live <= nxt_live;
                skip <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/simt_mask_stack.sv
module simt_mask_stack
    import simt_mask_pkg::*;
#(
    parameter int LANES = 64,
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch,
    input  logic [LANES-1:0]   launch_mask,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd,
    input  logic [LANES-1:0]   cond,
    input  logic               pixel_mode,
    output logic [LANES-1:0]   exec_mask,
    output logic [PW-1:0]      depth,
    output logic               skip,
    output logic               overflow,
    output logic               underflow,
    output logic               null_export,
    output logic               terminate
);

    mask_cmd_e        op;
    logic [LANES-1:0] top, nxt_live, nxt_entry;
    logic             push, pop, repl, clear;
    logic             full, empty, running;

    assign op = mask_cmd_e'(cmd);

    simt_mask_alu #(.LANES(LANES)) u_alu (
        .op        (op),
        .live      (exec_mask),
        .cond      (cond),
        .top       (top),
        .nxt_live  (nxt_live),
        .nxt_entry (nxt_entry)
    );

    simt_lane_stack #(.LANES(LANES), .DEPTH(DEPTH)) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear),
        .push  (push),
        .pop   (pop),
        .repl  (repl),
        .wdata (nxt_entry),
        .top   (top),
        .level (depth),
        .full  (full),
        .empty (empty)
    );

    simt_wave_ctrl #(.LANES(LANES)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch),
        .launch_mask (launch_mask),
        .cmd_valid   (cmd_valid),
        .op          (op),
        .pixel_mode  (pixel_mode),
        .nxt_live    (nxt_live),
        .full        (full),
        .empty       (empty),
        .last_level  (depth == PW'(1)),
        .live        (exec_mask),
        .push        (push),
        .pop         (pop),
        .repl        (repl),
        .clear       (clear),
        .running     (running),
        .skip        (skip),
        .overflow    (overflow),
        .underflow   (underflow),
        .null_export (null_export),
        .terminate   (terminate)
    );

endmodule

// File: rtl/simt_mask_chk.sv
module simt_mask_chk #(
    parameter int LANES = 64,
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             launch,
    input logic [LANES-1:0] launch_mask,
    input logic             cmd_valid,
    input logic [1:0]       cmd,
    input logic [LANES-1:0] cond,
    input logic             running,
    input logic [LANES-1:0] exec_mask,
    input logic [PW-1:0]    depth,
    input logic             skip,
    input logic             overflow,
    input logic             underflow,
    input logic             null_export,
    input logic             terminate
);

    logic if_ok;
    assign if_ok = running && !launch && cmd_valid && cmd == 2'b01 && depth < PW'(DEPTH);

    // R2
    if_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        if_ok |=> exec_mask == $past(exec_mask & cond));

    // R2
    if_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        if_ok |=> depth == $past(depth) + PW'(1));

    // R5
    skip_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        skip |-> exec_mask == '0);

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> $stable(exec_mask) && $stable(depth) && depth == PW'(DEPTH));

    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> $stable(exec_mask) && depth == '0);

    // R8
    export_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        null_export |-> depth == '0 && exec_mask == '0);

    // R8
    term_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        terminate |-> $past(null_export));

    // R10
    launch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> exec_mask == $past(launch_mask) && depth == '0 && !skip);

    // R11
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= PW'(DEPTH));

    // R8
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({overflow, underflow, null_export, terminate}));

endmodule

bind simt_mask_stack simt_mask_chk #(.LANES(LANES), .DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch      (launch),
    .launch_mask (launch_mask),
    .cmd_valid   (cmd_valid),
    .cmd         (cmd),
    .cond        (cond),
    .running     (running),
    .exec_mask   (exec_mask),
    .depth       (depth),
    .skip        (skip),
    .overflow    (overflow),
    .underflow   (underflow),
    .null_export (null_export),
    .terminate   (terminate)
);

// File: tb/sim_simt_mask_stack.sv
module sim_simt_mask_stack;

    localparam int LANES = 64;
    localparam int DEPTH = 8;
    localparam int PW    = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             launch = 1'b0;
    logic [LANES-1:0] launch_mask = '1;
    logic             cmd_valid = 1'b0;
    logic [1:0]       cmd = 2'b00;
    logic [LANES-1:0] cond = '0;
    logic             pixel_mode = 1'b0;
    logic [LANES-1:0] exec_mask;
    logic [PW-1:0]    depth;
    logic             skip, overflow, underflow, null_export, terminate;

    always #4 clk = ~clk;

    simt_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .launch(launch), .launch_mask(launch_mask),
        .cmd_valid(cmd_valid), .cmd(cmd), .cond(cond), .pixel_mode(pixel_mode),
        .exec_mask(exec_mask), .depth(depth), .skip(skip), .overflow(overflow),
        .underflow(underflow), .null_export(null_export), .terminate(terminate)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference model state
    logic [LANES-1:0] m_exec;
    logic [LANES-1:0] m_stk [DEPTH];
    int               m_dep;
    int               m_ph;
    bit               m_skip, m_ovf, m_unf;
    string            tag;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [LANES-1:0] act, input logic [LANES-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic void model_edge(input bit l, input logic [LANES-1:0] lm, input bit v,
                                       input logic [1:0] c, input logic [LANES-1:0] cd,
                                       input bit pix);
        logic [LANES-1:0] t;
        m_ovf = 1'b0;
        m_unf = 1'b0;
        if (l) begin
            m_exec = lm; m_dep = 0; m_ph = 0; m_skip = 1'b0; tag = "R10";
        end else if (m_ph == 1) begin
            m_ph = 2; tag = "R8";
        end else if (m_ph == 2) begin
            m_ph = 3; tag = "R8";
        end else if (m_ph == 3) begin
            tag = "R8";
        end else if (!v || c == 2'b00) begin
            tag = "R11";
        end else if (c == 2'b01) begin
            if (m_dep == DEPTH) begin
                m_ovf = 1'b1; tag = "R6";
            end else begin
                m_stk[m_dep] = m_exec & ~cd;
                m_exec = m_exec & cd;
                m_dep++;
                m_skip = (m_exec == '0);
                tag = "R2";
            end
        end else if (m_dep == 0) begin
            m_unf = 1'b1; tag = "R7";
        end else if (c == 2'b10) begin
            t = m_stk[m_dep-1];
            m_stk[m_dep-1] = m_exec;
            m_exec = t;
            m_skip = (m_exec == '0);
            tag = "R3";
        end else begin
            m_exec = m_exec | m_stk[m_dep-1];
            m_dep--;
            m_skip = 1'b0;
            tag = "R4";
            if (pix && m_dep == 0 && m_exec == '0) begin
                m_ph = 1; tag = "R8";
            end else if (m_dep == 0) begin
                tag = "R9";
            end
        end
    endfunction

    task automatic compare_all();
        chk(exec_mask == m_exec, tag, "exec_mask", exec_mask, m_exec);
        chk(depth == PW'(m_dep), tag, "depth", LANES'(depth), LANES'(m_dep));
        chk(skip == m_skip, "R5", "skip", LANES'(skip), LANES'(m_skip));
        chk(overflow == m_ovf, "R6", "overflow", LANES'(overflow), LANES'(m_ovf));
        chk(underflow == m_unf, "R7", "underflow", LANES'(underflow), LANES'(m_unf));
        chk(null_export == (m_ph == 1), (m_ph == 1) ? "R8" : "R9", "null_export",
            LANES'(null_export), LANES'(m_ph == 1));
        chk(terminate == (m_ph == 2), (m_ph == 2) ? "R8" : "R9", "terminate",
            LANES'(terminate), LANES'(m_ph == 2));
    endtask

    // Called at a falling edge; drives, waits one rising edge, checks at the next falling edge
    task automatic step(input bit l, input logic [LANES-1:0] lm, input bit v,
                        input logic [1:0] c, input logic [LANES-1:0] cd, input bit pix);
        launch = l; launch_mask = lm; cmd_valid = v; cmd = c; cond = cd; pixel_mode = pix;
        @(posedge clk);
        model_edge(l, lm, v, c, cd, pix);
        @(negedge clk);
        launch = 1'b0; cmd_valid = 1'b0; cmd = 2'b00;
        compare_all();
    endtask

    function automatic logic [LANES-1:0] rnd_mask();
        int r = int'($urandom % 8);
        if (r == 0) return '0;
        if (r == 1) return '1;
        return {$urandom, $urandom};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd77123));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        m_exec = '1; m_dep = 0; m_ph = 0; m_skip = 0; m_ovf = 0; m_unf = 0;
        for (int i = 0; i < DEPTH; i++) m_stk[i] = '0;
        tag = "R1";
        compare_all();

        // R6 fill to DEPTH, one extra IF overflows
        for (int i = 0; i < DEPTH + 1; i++) step(0, '1, 1, 2'b01, ~(64'd1 << i), 0);
        // R4 unwind back to the start
        for (int i = 0; i < DEPTH; i++) step(0, '1, 1, 2'b11, '0, 0);
        // R7 underflow on both commands
        step(0, '1, 1, 2'b11, '0, 0);
        step(0, '1, 1, 2'b10, '0, 0);
        // R5 zero condition raises skip; R3 else gets all lanes; R9 non-zero close in pixel mode
        step(0, '1, 1, 2'b01, '0, 1);
        step(0, '1, 1, 2'b10, '0, 1);
        step(0, '1, 1, 2'b11, '0, 1);
        // R9 zero close outside pixel mode
        step(1, '0, 0, 2'b00, '0, 0);
        step(0, '1, 1, 2'b01, '1, 0);
        step(0, '1, 1, 2'b11, '0, 0);
        // R8 zero close in pixel mode, then commands are ignored while halted
        step(0, '1, 1, 2'b01, '1, 1);
        step(0, '1, 1, 2'b11, '0, 1);
        step(0, '1, 1, 2'b01, '1, 1);
        step(0, '1, 1, 2'b01, '1, 1);
        step(0, '1, 1, 2'b01, '1, 1);
        step(0, '1, 1, 2'b11, '0, 1);
        // R10 launch wins over a command in the same cycle
        step(1, 64'h00ff_00ff_f0f0_1234, 1, 2'b01, '0, 0);
        step(0, '1, 1, 2'b01, 64'h0f0f_0f0f_0f0f_0f0f, 0);
        step(0, '1, 1, 2'b10, '0, 0);
        step(0, '1, 0, 2'b11, '0, 0);
        step(0, '1, 1, 2'b11, '0, 0);

        // Random mix
        for (int n = 0; n < 4000; n++) begin
            int r = int'($urandom % 100);
            logic [1:0] c;
            if (r < 40)      c = 2'b01;
            else if (r < 60) c = 2'b10;
            else if (r < 90) c = 2'b11;
            else             c = 2'b00;
            if (($urandom % 100) < 3)
                step(1, (($urandom % 4) == 0) ? rnd_mask() : '1, $urandom % 2, c, rnd_mask(),
                     $urandom % 2);
            else
                step(0, '1, ($urandom % 8) != 0, c, rnd_mask(), $urandom % 2);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule